// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Control

This block holds the control half of an in-order five-stage pipeline (fetch, decode, execute, memory, writeback). It keeps a short descriptor for each instruction in the decode, execute, memory and writeback latches. A descriptor holds the valid bit, the operation class, two source register numbers, a destination register number and a register-write enable. From these descriptors it works out three things each cycle. The first is where each execute-stage ALU operand and the store data should come from. The second is whether the decode instruction must wait behind a load. The third is whether the two youngest instructions must be discarded because a branch in execute was taken.

The fetch stage presents the descriptor of the instruction it is fetching. The block captures that descriptor into the decode latch when `fd_en` is high, and moves the older descriptors down the pipe every cycle. The datapath uses `sel_a`, `sel_b` and `sel_sd` to steer its bypass multiplexers. It uses `pc_en` and `fd_en` as write enables for the program counter and the decode latch. `dx_nop` tells it to load a bubble with cleared control into the execute latch. The register file, memories and ALU sit outside the block.

Top module: `hazard_fwd_ctl`

## Requirements
- R1: `sel_a` steers ALU operand A of the execute instruction. It is 0 when that instruction's first source equals the destination of the memory-stage producer, 1 when it equals the destination of the writeback-stage producer, and 2 (register file) otherwise. The value 3 never appears.
- R2: When both the memory-stage and writeback-stage producers write the same matching register, the select is 0, so the younger result wins.
- R3: `sel_b` applies the same rule as R1 and R2 to the execute instruction's second source, independently of `sel_a`.
- R4: `sel_sd` is 1 exactly when the memory stage holds a store (class 2) whose second source equals the destination of a load (class 1) in writeback. This path never changes `sel_a`, the address operand.
- R5: `stall` is 1 when the execute instruction is a load and the decode instruction's first source equals the load's destination. It is also 1 when the decode instruction's second source equals that destination and the decode instruction is not a store.
- R6: While `stall` is 1, `pc_en` and `fd_en` are 0, `dx_nop` is 1, the decode latch keeps its instruction, and the older stages keep advancing.
- R7: A load followed directly by a dependent instruction costs exactly one bubble. In the next cycle `stall` is 0 and the dependent instruction reaches execute with `sel_a` or `sel_b` set to 1.
- R8: When `ex_taken` is 1 and the execute latch holds a valid branch (class 3), `flush` and `dx_nop` are 1, and the decode and execute latches become bubbles. The squashed instructions never show up as producers. `ex_taken` has no effect when the execute instruction is not a valid branch.
- R9: Register 0 and invalid (bubble) descriptors never match, so they cause neither a forward nor a stall.
- R10: An instruction whose write enable is 0 is never treated as a producer.
- R11: While reset is low, all latches are bubbles. The selects read 2, and `stall`, `flush`, `dx_nop` and `sel_sd` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| f_valid | input | 1 | Fetched descriptor is a real instruction |
| f_op | input | 2 | Class: 0 ALU, 1 load, 2 store, 3 branch |
| f_rs1 | input | RW | First source register |
| f_rs2 | input | RW | Second source register (store data for stores) |
| f_rd | input | RW | Destination register |
| f_wen | input | 1 | Instruction writes its destination |
| ex_taken | input | 1 | Branch in execute resolved taken |
| sel_a | output | 2 | Operand A source: 0 memory stage, 1 writeback, 2 register file |
| sel_b | output | 2 | Operand B source, same encoding |
| sel_sd | output | 1 | Store data taken from the writeback load |
| stall | output | 1 | Load-use interlock active |
| pc_en | output | 1 | Program counter write enable |
| fd_en | output | 1 | Decode latch write enable |
| dx_nop | output | 1 | Load a bubble into the execute latch |
| flush | output | 1 | Squash the decode and execute instructions |

## Verification
The assertions assume that stores and branches arrive with a write enable of 0. They also assume that `ex_taken` is raised only in cycles whose execute instruction is a branch. Finally, they assume that the fetch side holds its descriptor steady while `pc_en` is low, because a stalled decode latch must keep its contents. The stimulus table follows these rules: in every row after a stall it presents the held instruction again. It gives every branch and store a cleared write enable, and it raises `ex_taken` on an invalid execute slot only once, to show that the input is then ignored.

// File: rtl/hazard_fwd_ctl.sv
module hazard_fwd_ctl #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          f_valid,
  input  logic [1:0]    f_op,
  input  logic [RW-1:0] f_rs1,
  input  logic [RW-1:0] f_rs2,
  input  logic [RW-1:0] f_rd,
  input  logic          f_wen,
  input  logic          ex_taken,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          sel_sd,
  output logic          stall,
  output logic          pc_en,
  output logic          fd_en,
  output logic          dx_nop,
  output logic          flush
);
  localparam logic [1:0] OP_LD = 2'd1, OP_ST = 2'd2, OP_BR = 2'd3;
  localparam logic [1:0] SEL_XM = 2'd0, SEL_MW = 2'd1, SEL_RF = 2'd2;

  typedef struct packed {
    logic          v;
    logic [1:0]    op;
    logic [RW-1:0] rs1;
    logic [RW-1:0] rs2;
    logic [RW-1:0] rd;
    logic          wen;
  } slot_t;

  slot_t fd_q, dx_q, xm_q, mw_q, fetch_d;

  function automatic logic writes(input slot_t s, input logic [RW-1:0] r);
    return s.v && s.wen && (s.rd != '0) && (s.rd == r);
  endfunction

  function automatic logic [1:0] pick(input logic [RW-1:0] r, input slot_t near, input slot_t far);
    if (writes(near, r)) return SEL_XM;
    if (writes(far, r))  return SEL_MW;
    return SEL_RF;
  endfunction

  assign fetch_d = '{v: f_valid, op: f_op, rs1: f_rs1, rs2: f_rs2, rd: f_rd, wen: f_wen};

  assign flush  = dx_q.v && (dx_q.op == OP_BR) && ex_taken;
  assign stall  = dx_q.v && (dx_q.op == OP_LD) && fd_q.v &&
                  (writes(dx_q, fd_q.rs1) || (writes(dx_q, fd_q.rs2) && (fd_q.op != OP_ST)));
  assign pc_en  = !stall;
  assign fd_en  = !stall;
  assign dx_nop = stall || flush;

  assign sel_a  = dx_q.v ? pick(dx_q.rs1, xm_q, mw_q) : SEL_RF;
  assign sel_b  = dx_q.v ? pick(dx_q.rs2, xm_q, mw_q) : SEL_RF;
  assign sel_sd = xm_q.v && (xm_q.op == OP_ST) && (mw_q.op == OP_LD) && writes(mw_q, xm_q.rs2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fd_q <= '0;
      dx_q <= '0;
      xm_q <= '0;
      mw_q <= '0;
    end else begin
      if (flush)      fd_q <= '0;
      else if (fd_en) fd_q <= fetch_d;
      dx_q <= dx_nop ? '0 : fd_q;
      xm_q <= dx_q;
      mw_q <= xm_q;
    end
  end
endmodule

module hazard_fwd_ctl_chk #(
  parameter int RW = 5,
  localparam int SW = 3 * RW + 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [SW-1:0] fd_q,
  input logic [SW-1:0] dx_q,
  input logic [SW-1:0] xm_q,
  input logic [SW-1:0] mw_q,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic          sel_sd,
  input logic          stall,
  input logic          flush
);
  // R1
  sel_a_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_a != 2'd3);

  // R1
  sel_a_near_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 2'd0) |-> (xm_q[SW-1] && xm_q[0] && (xm_q[RW:1] != '0)));

  // R3
  sel_b_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_b != 2'd3);

  // R4
  store_data_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_sd |-> (xm_q[SW-1] && xm_q[SW-2:SW-3] == 2'd2 && mw_q[SW-1] && mw_q[SW-2:SW-3] == 2'd1));

  // R6
  stall_holds_fd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(fd_q));

  // R6
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !dx_q[SW-1]);

  // R6
  older_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xm_q == $past(dx_q)) && (mw_q == $past(xm_q)));

  // R7
  one_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!fd_q[SW-1] && !dx_q[SW-1]));

  // R9
  bubble_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dx_q[SW-1] |-> (sel_a == 2'd2 && sel_b == 2'd2));
endmodule

bind hazard_fwd_ctl hazard_fwd_ctl_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fd_q(fd_q), .dx_q(dx_q), .xm_q(xm_q), .mw_q(mw_q),
  .sel_a(sel_a), .sel_b(sel_b), .sel_sd(sel_sd), .stall(stall), .flush(flush)
);

// File: tb/hazard_fwd_ctl_bench.sv
module hazard_fwd_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic f_valid = 1'b0, f_wen = 1'b0, ex_taken = 1'b0;
  logic [1:0] f_op = '0;
  logic [4:0] f_rs1 = '0, f_rs2 = '0, f_rd = '0;
  logic [1:0] sel_a, sel_b;
  logic sel_sd, stall, pc_en, fd_en, dx_nop, flush;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  hazard_fwd_ctl u_hazard_fwd_ctl (
    .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_op(f_op), .f_rs1(f_rs1),
    .f_rs2(f_rs2), .f_rd(f_rd), .f_wen(f_wen), .ex_taken(ex_taken),
    .sel_a(sel_a), .sel_b(sel_b), .sel_sd(sel_sd), .stall(stall), .pc_en(pc_en),
    .fd_en(fd_en), .dx_nop(dx_nop), .flush(flush)
  );

  // descriptor {v, op, rs1, rs2, rd, wen}
  function automatic logic [18:0] iA(input int a, input int b, input int d);
    return {1'b1, 2'd0, 5'(a), 5'(b), 5'(d), 1'b1};
  endfunction
  function automatic logic [18:0] iW(input int a, input int b, input int d);
    return {1'b1, 2'd0, 5'(a), 5'(b), 5'(d), 1'b0};
  endfunction
  function automatic logic [18:0] iL(input int a, input int d);
    return {1'b1, 2'd1, 5'(a), 5'd0, 5'(d), 1'b1};
  endfunction
  function automatic logic [18:0] iS(input int a, input int b);
    return {1'b1, 2'd2, 5'(a), 5'(b), 5'd0, 1'b0};
  endfunction
  function automatic logic [18:0] iB(input int a, input int b);
    return {1'b1, 2'd3, 5'(a), 5'(b), 5'd0, 1'b0};
  endfunction
  function automatic logic [18:0] iX(input int a);
    return {1'b0, 2'd0, 5'(a), 5'd0, 5'd0, 1'b0};
  endfunction
  localparam logic [18:0] NOP = '0;

  // row {ins, taken, exp sel_a, exp sel_b, exp sel_sd, exp stall, exp flush}
  function automatic logic [26:0] rw(input logic [18:0] i, input logic br, input int fa,
                                     input int fb, input logic fs, input logic st, input logic fl);
    return {i, br, 2'(fa), 2'(fb), fs, st, fl};
  endfunction

  localparam int N = 48;
  localparam logic [26:0] VEC [N] = '{
    rw(iA(1,2,3),0,2,2,0,0,0), rw(iA(3,4,5),0,2,2,0,0,0), rw(iA(3,5,6),0,2,2,0,0,0),
    rw(NOP,0,0,2,0,0,0),       // R1 memory-stage forward to A
    rw(NOP,0,1,0,0,0,0),       // R1 writeback to A, R3 memory stage to B
    rw(iA(7,7,7),0,2,2,0,0,0), rw(iA(7,7,7),0,2,2,0,0,0), rw(iA(7,0,8),0,2,2,0,0,0),
    rw(NOP,0,0,0,0,0,0),       // R3 both operands from one producer
    rw(NOP,0,0,2,0,0,0),       // R2 younger wins, R9 register 0 source
    rw(iA(0,0,0),0,2,2,0,0,0), rw(iW(11,12,9),0,2,2,0,0,0), rw(iA(9,9,13),0,2,2,0,0,0),
    rw(NOP,0,2,2,0,0,0),
    rw(NOP,0,2,2,0,0,0),       // R10 no-write producer, R9 rd 0 producer
    rw(iL(1,4),0,2,2,0,0,0), rw(iA(4,2,5),0,2,2,0,0,0),
    rw(iA(1,1,1),0,2,2,0,1,0), // R5 load-use on source 1
    rw(iA(1,1,1),0,2,2,0,0,0), // R7 held instruction, no second stall
    rw(NOP,0,1,2,0,0,0),       // R7 dependent reaches execute via writeback
    rw(iL(2,6),0,2,2,0,0,0), rw(iS(3,6),0,2,2,0,0,0),
    rw(NOP,0,2,2,0,0,0),       // R5 store data source exempt
    rw(NOP,0,2,0,0,0,0),
    rw(NOP,0,2,2,1,0,0),       // R4 store-data bypass
    rw(iL(2,7),0,2,2,0,0,0), rw(iS(7,1),0,2,2,0,0,0),
    rw(NOP,0,2,2,0,1,0),       // R5 store address from load stalls
    rw(NOP,0,2,2,0,0,0),
    rw(NOP,0,1,2,0,0,0),       // R4 address path uses operand A only
    rw(NOP,0,2,2,0,0,0),
    rw(iB(2,3),0,2,2,0,0,0),
    rw(iA(1,2,3),1,2,2,0,0,0), // R8 taken ignored without branch in execute
    rw(iA(3,4,5),1,2,2,0,0,1), // R8 taken branch flushes
    rw(iA(5,0,6),0,2,2,0,0,0), rw(NOP,0,2,2,0,0,0),
    rw(NOP,0,2,2,0,0,0),       // R8 squashed rd5 never forwards
    rw(iL(1,9),0,2,2,0,0,0), rw(iX(9),0,2,2,0,0,0),
    rw(NOP,0,2,2,0,0,0),       // R9 invalid decode slot no stall
    rw(iL(1,0),0,2,2,0,0,0), rw(iA(0,0,2),0,2,2,0,0,0),
    rw(NOP,0,2,2,0,0,0),       // R9 load to r0 no stall
    rw(iL(3,10),0,2,2,0,0,0), rw(iA(1,10,11),0,2,2,0,0,0),
    rw(NOP,0,2,2,0,1,0),       // R5 load-use on source 2
    rw(NOP,0,2,2,0,0,0),
    rw(NOP,0,2,1,0,0,0)        // R7 operand B from writeback
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [18:0] i, input logic br);
    {f_valid, f_op, f_rs1, f_rs2, f_rd, f_wen} = i;
    ex_taken = br;
  endtask

  task automatic chk_all(input int fa, input int fb, input logic fs, input logic st, input logic fl);
    chk("R1 sel_a", sel_a, fa);
    chk("R3 sel_b", sel_b, fb);
    chk("R4 sel_sd", sel_sd, fs);
    chk("R5 stall", stall, st);
    chk("R8 flush", flush, fl);
    chk("R6 pc_en", pc_en, !st);
    chk("R6 fd_en", fd_en, !st);
    chk("R6 dx_nop", dx_nop, st | fl);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk_all(2, 2, 0, 0, 0);   // R11 reset state
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      drive(VEC[k][26:8], VEC[k][7]);
      #2;
      chk_all(int'(VEC[k][6:5]), int'(VEC[k][4:3]), VEC[k][2], VEC[k][1], VEC[k][0]);
    end
    // R11 reset during a live stall clears every latch
    @(negedge clk); drive(iL(2,12), 0);
    @(negedge clk); drive(iA(12,0,13), 0);
    @(negedge clk); drive(NOP, 0);
    #2;
    chk("R5 stall before reset", stall, 1);
    rst_n = 1'b0;
    #1;
    chk_all(2, 2, 0, 0, 0);   // R11
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk_all(2, 2, 0, 0, 0);   // R11 nothing survives reset
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule